// File: doc/BRIEF.md
# Boot ROM Strap Configuration Unit

This unit fixes how the boot ROM is reached before any firmware runs. While the synchronous reset is high, it samples four strap inputs on every clock. The last edge of reset therefore sets the initial configuration, and after that the straps are ignored. Two straps carry a width code for the boot chip-select decode. One strap chooses where that decode goes: the dedicated boot chip-select pin or the chip select of card socket A. One strap turns on the external data buffer controls. An open strap reads as 0, so an unstrapped board boots from an 8-bit ROM on the dedicated pin, with the buffer controls off.

Once reset is over, firmware can rewrite the width and the routing through a single-cycle write strobe. If a write arrives while a boot ROM access is in progress, it is held until that access ends. The block refuses any configuration that routes the decode to the card socket with a 32-bit width. A refused strap setting falls back to the pin route. A refused write changes nothing. Both cases set a sticky flag. A reserved width code is treated as 8-bit and sets its own sticky flag.

All chip-select and buffer outputs are qualified by the access strobe `rom_cyc_i` and are combinational from it and the held configuration.

Top module: `bstrap_cfg_top`

## Requirements
- R1: With all straps at 0 during reset, after reset `width_o`=00, `card_route_o`=0, both error flags are 0, and no buffer output goes high during an access.
- R2: Straps are sampled only while `rst` is high. Changing `strap_i` after reset changes no output.
- R3: Width code `strap_i[1:0]` (and `cfg_wr_width_i`) maps 00 to 8-bit, 10 to 16-bit and 11 to 32-bit, shown on `width_o` with the same code. Code 01 is reserved: it appears as 00 and sets `rsv_err_o`.
- R4: `strap_i[2]`=0 routes the decode to the pin and `strap_i[2]`=1 routes it to the card. During an access (`rom_cyc_i`=1) exactly one of `boot_cs_o`/`card_cs_o` is high, as selected by `card_route_o`. Outside an access both are 0.
- R5: `rom32_oe_o` is high exactly when `rom_cyc_i`=1 and `width_o`=11, whichever route is selected.
- R6: `strap_i[3]` alone enables the buffer controls, regardless of width. `dbuf_oe_o` = enable AND `rom_cyc_i`. `dbuf_rdl_o` and `dbuf_rdh_o` = enable AND `rom_cyc_i` AND `rom_rd_i`.
- R7: Straps that request card routing with width 11 give `width_o`=11, `card_route_o`=0 and `combo_err_o`=1.
- R8: A write (`cfg_wr_i`=1) on an edge where `rom_cyc_i`=0 loads width and route on that edge.
- R9: A write on an edge where `rom_cyc_i`=1 is held, and is applied on the first later edge where `rom_cyc_i`=0. Width and route never change between two edges of an access.
- R10: A write requesting card routing with width 11 leaves width and route unchanged and sets `combo_err_o`.
- R11: A reserved width write loads 8-bit and sets `rsv_err_o`. Both error flags stay set until the next reset.
- R12: `card_route_o` and `width_o`=11 are never true together, and `width_o` never shows 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; straps are sampled while high |
| strap_i | input | 4 | [1:0] width code, [2] route to card, [3] buffer control enable |
| rom_cyc_i | input | 1 | High during a boot ROM decode access |
| rom_rd_i | input | 1 | High when the access is a read |
| cfg_wr_i | input | 1 | Firmware write strobe |
| cfg_wr_width_i | input | 2 | Width code to write |
| cfg_wr_card_i | input | 1 | Route to write (1 = card socket) |
| boot_cs_o | output | 1 | Dedicated boot chip-select |
| card_cs_o | output | 1 | Card socket A chip-select |
| rom32_oe_o | output | 1 | 32-bit ROM buffer output enable |
| dbuf_oe_o | output | 1 | Data buffer output enable |
| dbuf_rdl_o | output | 1 | Low-half buffer read direction |
| dbuf_rdh_o | output | 1 | High-half buffer read direction |
| width_o | output | 2 | Current width code |
| card_route_o | output | 1 | Current route (1 = card) |
| rsv_err_o | output | 1 | Sticky reserved-width flag |
| combo_err_o | output | 1 | Sticky refused-combination flag |

## Verification
A wrong held configuration appears on `width_o` and `card_route_o` on the first clock after the edge that loaded it. It also appears on the chip-select and buffer outputs as soon as `rom_cyc_i` rises, because those outputs add no register. A write applied too early shows up as a change of width or route in the middle of an access. A dropped or lost pending write shows up one clock after the access ends, when the expected update does not appear. Flags that clear, or that never set, are visible on the clock following the offending write or reset.

// File: rtl/bstrap_pkg.sv
package bstrap_pkg;
    localparam int STRAP_W  = 4;
    localparam int WCODE_W  = 2;
    localparam int S_WIDTH0 = 0;
    localparam int S_CARD   = 2;
    localparam int S_BUFEN  = 3;

    typedef enum logic [WCODE_W-1:0] {
        W_8   = 2'b00,
        W_RSV = 2'b01,
        W_16  = 2'b10,
        W_32  = 2'b11
    } rom_width_e;

    typedef struct packed {
        rom_width_e width;
        logic       to_card;
        logic       buf_en;
    } boot_cfg_t;

    typedef struct packed {
        boot_cfg_t cfg;
        logic      rsv_hit;
        logic      combo_hit;
    } cfg_eval_t;

    // Normalise a requested setting: reserved width becomes 8-bit, card+32 is flagged
    function automatic cfg_eval_t eval_cfg(input logic [WCODE_W-1:0] wcode,
                                           input logic card, input logic buf_en);
        cfg_eval_t r;
        r.rsv_hit       = (wcode == W_RSV);
        r.cfg.width     = r.rsv_hit ? W_8 : rom_width_e'(wcode);
        r.combo_hit     = card && (r.cfg.width == W_32);
        r.cfg.to_card   = card && !r.combo_hit;
        r.cfg.buf_en    = buf_en;
        return r;
    endfunction
endpackage

// File: rtl/bstrap_cfg_reg.sv
module bstrap_cfg_reg
    import bstrap_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               commit_i,
    input  cfg_eval_t          commit_eval_i,
    output boot_cfg_t          cfg_o,
    output logic               rsv_err_o,
    output logic               combo_err_o
);
    cfg_eval_t strap_eval;
    boot_cfg_t cfg_q;
    logic      rsv_q;
    logic      combo_q;

    assign strap_eval = eval_cfg(strap_i[S_WIDTH0 +: WCODE_W], strap_i[S_CARD], strap_i[S_BUFEN]);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= strap_eval.cfg;
            rsv_q   <= strap_eval.rsv_hit;
            combo_q <= strap_eval.combo_hit;
        end else if (commit_i) begin
            rsv_q   <= rsv_q | commit_eval_i.rsv_hit;
            combo_q <= combo_q | commit_eval_i.combo_hit;
            if (!commit_eval_i.combo_hit) begin
                cfg_q.width   <= commit_eval_i.cfg.width;
                cfg_q.to_card <= commit_eval_i.cfg.to_card;
            end
        end
    end

    assign cfg_o       = cfg_q;
    assign rsv_err_o   = rsv_q;
    assign combo_err_o = combo_q;
endmodule

// File: rtl/bstrap_wr_ctrl.sv
module bstrap_wr_ctrl
    import bstrap_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               rom_cyc_i,
    input  logic               wr_i,
    input  logic [WCODE_W-1:0] wr_width_i,
    input  logic               wr_card_i,
    output logic               commit_o,
    output cfg_eval_t          commit_eval_o
);
    logic               pend_q;
    logic [WCODE_W-1:0] pend_width_q;
    logic               pend_card_q;
    logic               have_req;
    logic [WCODE_W-1:0] src_width;
    logic               src_card;

    always_comb begin
        have_req  = wr_i | pend_q;
        src_width = wr_i ? wr_width_i : pend_width_q;
        src_card  = wr_i ? wr_card_i : pend_card_q;
    end

    assign commit_o      = have_req && !rom_cyc_i;
    assign commit_eval_o = eval_cfg(src_width, src_card, 1'b0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q       <= 1'b0;
            pend_width_q <= '0;
            pend_card_q  <= 1'b0;
        end else if (have_req && rom_cyc_i) begin
            pend_q       <= 1'b1;
            pend_width_q <= src_width;
            pend_card_q  <= src_card;
        end else if (commit_o) begin
            pend_q       <= 1'b0;
        end
    end
endmodule

// File: rtl/bstrap_out_gate.sv
module bstrap_out_gate
    import bstrap_pkg::*;
(
    input  boot_cfg_t cfg_i,
    input  logic      rom_cyc_i,
    input  logic      rom_rd_i,
    output logic      boot_cs_o,
    output logic      card_cs_o,
    output logic      rom32_oe_o,
    output logic      dbuf_oe_o,
    output logic      dbuf_rdl_o,
    output logic      dbuf_rdh_o
);
    logic buf_act;

    always_comb begin
        boot_cs_o  = rom_cyc_i && !cfg_i.to_card;
        card_cs_o  = rom_cyc_i && cfg_i.to_card;
        rom32_oe_o = rom_cyc_i && (cfg_i.width == W_32);
        buf_act    = rom_cyc_i && cfg_i.buf_en;
        dbuf_oe_o  = buf_act;
        dbuf_rdl_o = buf_act && rom_rd_i;
        dbuf_rdh_o = buf_act && rom_rd_i;
    end
endmodule

// File: rtl/bstrap_cfg_top.sv
module bstrap_cfg_top
    import bstrap_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               rom_cyc_i,
    input  logic               rom_rd_i,
    input  logic               cfg_wr_i,
    input  logic [WCODE_W-1:0] cfg_wr_width_i,
    input  logic               cfg_wr_card_i,
    output logic               boot_cs_o,
    output logic               card_cs_o,
    output logic               rom32_oe_o,
    output logic               dbuf_oe_o,
    output logic               dbuf_rdl_o,
    output logic               dbuf_rdh_o,
    output logic [WCODE_W-1:0] width_o,
    output logic               card_route_o,
    output logic               rsv_err_o,
    output logic               combo_err_o
);
    boot_cfg_t cfg;
    logic      commit;
    cfg_eval_t commit_eval;

    bstrap_wr_ctrl u_wr (
        .clk(clk), .rst(rst), .rom_cyc_i(rom_cyc_i),
        .wr_i(cfg_wr_i), .wr_width_i(cfg_wr_width_i), .wr_card_i(cfg_wr_card_i),
        .commit_o(commit), .commit_eval_o(commit_eval)
    );

    bstrap_cfg_reg u_reg (
        .clk(clk), .rst(rst), .strap_i(strap_i),
        .commit_i(commit), .commit_eval_i(commit_eval),
        .cfg_o(cfg), .rsv_err_o(rsv_err_o), .combo_err_o(combo_err_o)
    );

    bstrap_out_gate u_out (
        .cfg_i(cfg), .rom_cyc_i(rom_cyc_i), .rom_rd_i(rom_rd_i),
        .boot_cs_o(boot_cs_o), .card_cs_o(card_cs_o), .rom32_oe_o(rom32_oe_o),
        .dbuf_oe_o(dbuf_oe_o), .dbuf_rdl_o(dbuf_rdl_o), .dbuf_rdh_o(dbuf_rdh_o)
    );

    assign width_o      = cfg.width;
    assign card_route_o = cfg.to_card;
endmodule

// File: rtl/bstrap_cfg_chk.sv
module bstrap_cfg_chk (
    input logic       clk,
    input logic       rst,
    input logic       rom_cyc_i,
    input logic       boot_cs_o,
    input logic       card_cs_o,
    input logic       rom32_oe_o,
    input logic [1:0] width_o,
    input logic       card_route_o,
    input logic       rsv_err_o,
    input logic       combo_err_o
);
    p_cs_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
        !(boot_cs_o && card_cs_o));
    p_rom32_needs_w32_r5: assert property (@(posedge clk) disable iff (rst)
        rom32_oe_o |-> (width_o == 2'b11));
    p_no_card_w32_r12: assert property (@(posedge clk) disable iff (rst)
        !(card_route_o && width_o == 2'b11));
    p_no_rsv_width_r3: assert property (@(posedge clk) disable iff (rst)
        width_o != 2'b01);
    p_stable_in_access_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(rom_cyc_i)) |-> $stable({width_o, card_route_o}));
    p_rsv_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        rsv_err_o |=> rsv_err_o);
    p_combo_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        combo_err_o |=> combo_err_o);
endmodule

bind bstrap_cfg_top bstrap_cfg_chk u_chk (
    .clk(clk), .rst(rst), .rom_cyc_i(rom_cyc_i),
    .boot_cs_o(boot_cs_o), .card_cs_o(card_cs_o), .rom32_oe_o(rom32_oe_o),
    .width_o(width_o), .card_route_o(card_route_o),
    .rsv_err_o(rsv_err_o), .combo_err_o(combo_err_o)
);

// File: tb/bstrap_cfg_top_tb_top.sv
module bstrap_cfg_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] strap_i = '0;
    logic       rom_cyc_i = 1'b0, rom_rd_i = 1'b0;
    logic       cfg_wr_i = 1'b0;
    logic [1:0] cfg_wr_width_i = '0;
    logic       cfg_wr_card_i = 1'b0;
    logic boot_cs_o, card_cs_o, rom32_oe_o, dbuf_oe_o, dbuf_rdl_o, dbuf_rdh_o;
    logic [1:0] width_o;
    logic card_route_o, rsv_err_o, combo_err_o;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    bstrap_cfg_top dut_i (.*);

    // {strap[3:0], width[1:0], card, buf, rsv, combo}
    localparam logic [9:0] VEC [16] = '{
        10'b0000_00_0_0_0_0, 10'b0001_00_0_0_1_0, 10'b0010_10_0_0_0_0, 10'b0011_11_0_0_0_0,
        10'b0100_00_1_0_0_0, 10'b0101_00_1_0_1_0, 10'b0110_10_1_0_0_0, 10'b0111_11_0_0_0_1,
        10'b1000_00_0_1_0_0, 10'b1001_00_0_1_1_0, 10'b1010_10_0_1_0_0, 10'b1011_11_0_1_0_0,
        10'b1100_00_1_1_0_0, 10'b1101_00_1_1_1_0, 10'b1110_10_1_1_0_0, 10'b1111_11_0_1_0_1
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic do_reset(input logic [3:0] s);
        @(negedge clk);
        rst = 1'b1; strap_i = s; rom_cyc_i = 1'b0; rom_rd_i = 1'b0; cfg_wr_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        strap_i = ~s; // R2: straps changed after reset must be ignored
        @(negedge clk);
        #2;
    endtask

    task automatic fw_write(input logic [1:0] w, input logic c);
        @(negedge clk);
        cfg_wr_i = 1'b1; cfg_wr_width_i = w; cfg_wr_card_i = c;
        @(negedge clk);
        cfg_wr_i = 1'b0;
        #2;
    endtask

    initial begin
        #(20 * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        foreach (VEC[i]) begin
            logic [3:0] s;
            logic [1:0] w;
            logic c, b, rv, cb;
            {s, w, c, b, rv, cb} = VEC[i];
            do_reset(s);
            // R1 R2 R3 R7: held configuration and flags
            check("R3/R7 width,route", {5'b0, width_o, card_route_o}, {5'b0, w, c});
            check("R3/R7 flags", {6'b0, rsv_err_o, combo_err_o}, {6'b0, rv, cb});
            check("R4 idle outputs", {2'b0, boot_cs_o, card_cs_o, rom32_oe_o, dbuf_oe_o, dbuf_rdl_o, dbuf_rdh_o}, 8'h00);
            rom_cyc_i = 1'b1; rom_rd_i = 1'b1; #2;
            check("R4/R5/R6 read access", {2'b0, boot_cs_o, card_cs_o, rom32_oe_o, dbuf_oe_o, dbuf_rdl_o, dbuf_rdh_o},
                  {2'b0, !c, c, (w == 2'b11), b, b, b});
            rom_rd_i = 1'b0; #2;
            check("R6 write access", {5'b0, dbuf_oe_o, dbuf_rdl_o, dbuf_rdh_o}, {5'b0, b, 1'b0, 1'b0});
            rom_cyc_i = 1'b0;
        end

        // R1: default straps
        do_reset(4'b0000);
        check("R1 default", {3'b0, width_o, card_route_o, rsv_err_o, combo_err_o}, 8'h00);
        // R8: idle writes take effect
        fw_write(2'b10, 1'b1);
        check("R8 write 16/card", {5'b0, width_o, card_route_o}, {5'b0, 2'b10, 1'b1});
        fw_write(2'b11, 1'b0);
        check("R8 write 32/pin", {4'b0, width_o, card_route_o, combo_err_o}, {4'b0, 2'b11, 1'b0, 1'b0});
        // R10: refused combination
        fw_write(2'b11, 1'b1);
        check("R10 refused", {4'b0, width_o, card_route_o, combo_err_o}, {4'b0, 2'b11, 1'b0, 1'b1});
        fw_write(2'b10, 1'b1);
        check("R10 sticky after legal write", {4'b0, width_o, card_route_o, combo_err_o}, {4'b0, 2'b10, 1'b1, 1'b1});
        // R9: write during an access is deferred
        @(negedge clk); rom_cyc_i = 1'b1;
        fw_write(2'b00, 1'b0);
        check("R9 held during access", {5'b0, width_o, card_route_o}, {5'b0, 2'b10, 1'b1});
        @(negedge clk); #2;
        check("R9 still held", {5'b0, width_o, card_route_o}, {5'b0, 2'b10, 1'b1});
        rom_cyc_i = 1'b0; #2;
        check("R9 before edge", {5'b0, width_o, card_route_o}, {5'b0, 2'b10, 1'b1});
        @(negedge clk); #2;
        check("R9 applied after access", {5'b0, width_o, card_route_o}, {5'b0, 2'b00, 1'b0});
        // R11: reserved write and stickiness
        fw_write(2'b01, 1'b1);
        check("R11 reserved write", {4'b0, width_o, card_route_o, rsv_err_o}, {4'b0, 2'b00, 1'b1, 1'b1});
        fw_write(2'b10, 1'b0);
        check("R11 sticky", {4'b0, width_o, card_route_o, rsv_err_o}, {4'b0, 2'b10, 1'b0, 1'b1});
        // R1: reset clears flags
        do_reset(4'b0000);
        check("R1 flags cleared", {6'b0, rsv_err_o, combo_err_o}, 8'h00);

        summary();
        $finish;
    end
endmodule